// File: doc/BRIEF.md
# DSP Memory Space Select Decoder

This block turns the external bus of a 24-bit DSP into chip selects for the devices behind it. The DSP has a 16-bit address bus and three separate 64K-word spaces: program, X data and Y data. The space of the current cycle is identified by an active-low program strobe, an active-low data strobe and an X/Y line. Reads and writes use separate active-low strobes. The decoder forms three active-low selects from address bits 15, 14 and 13:
- one RAM select from the AND of bits 14 and 13;
- a second RAM select from their OR;
- a flash select for program-space fetches from the upper part of the map.

A host configures the decoder over a write-only SPI slave. One 8-bit frame enables or disables the RAM AND-term select and sets a 3-bit flash bank number. The bank number goes straight out on three lines that choose one of eight 16KB banks, 128KB in all. The SPI pins are sampled with the system clock, so the serial clock must run well below the system clock. The selects are combinational from the bus pins and the stored configuration. The bank lines and the configuration are registered.

Top module: `dsp_mem_decoder`

## Requirements
- R1: After reset the bank output is 0, the AND-term select is disabled and, with no strobe active, all three selects are high.
- R2: A bus access exists only when at least one space strobe is low (ps_ni or ds_ni) and at least one transfer strobe is low (rd_ni or wr_ni). Without an access, ram_and_sel_no, ram_or_sel_no and flash_sel_no are all high. The X/Y line never changes a select.
- R3: During an access, ram_or_sel_no is low exactly when addr_i[13] or addr_i[14] is 1.
- R4: During an access, ram_and_sel_no is low exactly when the enable bit is 1 and addr_i[14] and addr_i[13] are both 1. While the enable bit is 0 it stays high.
- R5: During an access, flash_sel_no is low exactly when ps_ni is 0, addr_i[15] is 1 and addr_i[14] equals addr_i[13]. With ps_ni high (data space only) it stays high. The program strobe takes priority if both space strobes are low.
- R6: SPI runs in mode 0, MSB first. spi_mosi_i is sampled on each rising spi_sck_i while spi_cs_ni is low. The frame is committed when spi_cs_ni rises: frame bit 7 becomes the enable bit and frame bits 2:0 become bank_o. Frame bits 6:3 are ignored.
- R7: A frame of fewer than 8 bits is discarded on the rise of chip select. A frame of more than 8 bits commits its last 8 bits.
- R8: bank_o and the enable bit keep their value between commits. Clock edges on spi_sck_i while spi_cs_ni is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_sck_i | input | 1 | SPI serial clock |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI serial data in |
| addr_i | input | 16 | DSP address bus |
| ps_ni | input | 1 | Program space strobe, active low |
| ds_ni | input | 1 | Data space strobe, active low |
| xy_i | input | 1 | X/Y data space line (1 = X) |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ram_and_sel_no | output | 1 | RAM select, AND term of A14/A13, active low |
| ram_or_sel_no | output | 1 | RAM select, OR term of A14/A13, active low |
| flash_sel_no | output | 1 | Flash select, active low |
| bank_o | output | 3 | Flash bank number |

## Verification
The bench sweeps every combination of the top three address bits with every combination of the five strobe and space lines, first with the AND term disabled and then enabled. A decoder that ignored a transfer strobe, or selected flash in data space, would show a low select where the model expects high. Frames carry set bits in the ignored field, which would corrupt the bank value if the field boundaries were wrong. Short and long frames catch a design that commits partial frames or keeps the first 8 bits instead of the last 8. Clock toggling with chip select high catches a receiver that shifts while deselected.

// File: rtl/dmd_pkg.sv
package dmd_pkg;
  localparam int ADDR_W  = 16;
  localparam int FRAME_W = 8;
  localparam int BANK_W  = 3;
  localparam int EN_BIT  = 7;

  typedef enum logic [1:0] {
    SP_NONE = 2'd0,
    SP_PROG = 2'd1,
    SP_X    = 2'd2,
    SP_Y    = 2'd3
  } space_e;

  typedef struct packed {
    logic              and_en;
    logic [BANK_W-1:0] bank;
  } cfg_t;
endpackage

// File: rtl/dmd_spi_rx.sv
module dmd_spi_rx #(
  parameter int FRAME_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_ni,
  input  logic               mosi_i,
  output logic               commit_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  // synchronizer chains: [0]=sck [1]=cs [2]=mosi
  logic [2:0] sync_q [SYNC_STAGES];
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[s] <= 3'b010;
      else if (s == 0) sync_q[s] <= {mosi_i, cs_ni, sck_i};
      else sync_q[s] <= sync_q[(s > 0) ? s - 1 : 0];
    end
  end

  logic sck_s, cs_s, mosi_s;
  assign {mosi_s, cs_s, sck_s} = sync_q[SYNC_STAGES-1];

  logic sck_q, cs_q;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;

  logic sck_rise, cs_rise;
  assign sck_rise = sck_s & ~sck_q & ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_s) begin
        cnt_q <= '0;
      end else if (sck_rise) begin
        shift_q <= {shift_q[FRAME_W-2:0], mosi_s};
        if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign commit_o = cs_rise & (cnt_q == FULL);
  assign frame_o  = shift_q;
endmodule

// File: rtl/dmd_cfg_reg.sv
module dmd_cfg_reg
  import dmd_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int BANK_W  = 3,
  parameter int EN_BIT  = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               and_en_o,
  output logic [BANK_W-1:0]  bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_en_o <= 1'b0;
      bank_o   <= '0;
    end else if (commit_i) begin
      and_en_o <= frame_i[EN_BIT];
      bank_o   <= frame_i[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/dmd_select.sv
module dmd_select
  import dmd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              ps_ni,
  input  logic              ds_ni,
  input  logic              xy_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              and_en_i,
  output logic              ram_and_sel_no,
  output logic              ram_or_sel_no,
  output logic              flash_sel_no
);
  localparam int A_HI = ADDR_W - 1;
  localparam int A_MD = ADDR_W - 2;
  localparam int A_LO = ADDR_W - 3;

  space_e space;
  always_comb begin
    if (!ps_ni)      space = SP_PROG;   // program strobe wins
    else if (!ds_ni) space = xy_i ? SP_X : SP_Y;
    else             space = SP_NONE;
  end

  logic access;
  assign access = (space != SP_NONE) & (~rd_ni | ~wr_ni);

  always_comb begin
    ram_or_sel_no  = ~(access & (addr_i[A_MD] | addr_i[A_LO]));
    ram_and_sel_no = ~(access & and_en_i & addr_i[A_MD] & addr_i[A_LO]);
    flash_sel_no   = ~(access & (space == SP_PROG) & addr_i[A_HI]
                       & ~(addr_i[A_MD] ^ addr_i[A_LO]));
  end
endmodule

// File: rtl/dsp_mem_decoder.sv
module dsp_mem_decoder
  import dmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_sck_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ps_ni,
  input  logic              ds_ni,
  input  logic              xy_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  output logic              ram_and_sel_no,
  output logic              ram_or_sel_no,
  output logic              flash_sel_no,
  output logic [BANK_W-1:0] bank_o
);
  logic               commit;
  logic [FRAME_W-1:0] frame;
  cfg_t               cfg;

  dmd_spi_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (spi_sck_i),
    .cs_ni    (spi_cs_ni),
    .mosi_i   (spi_mosi_i),
    .commit_o (commit),
    .frame_o  (frame)
  );

  dmd_cfg_reg #(.FRAME_W(FRAME_W), .BANK_W(BANK_W), .EN_BIT(EN_BIT)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .frame_i  (frame),
    .and_en_o (cfg.and_en),
    .bank_o   (cfg.bank)
  );

  dmd_select #(.ADDR_W(ADDR_W)) u_sel (
    .ps_ni          (ps_ni),
    .ds_ni          (ds_ni),
    .xy_i           (xy_i),
    .rd_ni          (rd_ni),
    .wr_ni          (wr_ni),
    .addr_i         (addr_i),
    .and_en_i       (cfg.and_en),
    .ram_and_sel_no (ram_and_sel_no),
    .ram_or_sel_no  (ram_or_sel_no),
    .flash_sel_no   (flash_sel_no)
  );

  assign bank_o = cfg.bank;
endmodule

// File: rtl/dmd_checker.sv
module dmd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        ps_ni,
  input logic        ds_ni,
  input logic        rd_ni,
  input logic        wr_ni,
  input logic        ram_and_sel_no,
  input logic        ram_or_sel_no,
  input logic        flash_sel_no,
  input logic [2:0]  bank_o,
  input logic        and_en_i,
  input logic        commit_i
);
  logic acc;
  assign acc = (~ps_ni | ~ds_ni) & (~rd_ni | ~wr_ni);

  a_r2_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> (ram_and_sel_no && ram_or_sel_no && flash_sel_no));

  a_r3_or_needs_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_i[13] || addr_i[14]) |-> ram_or_sel_no);

  a_r4_and_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !and_en_i |-> ram_and_sel_no);

  a_r5_flash_prog_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ps_ni |-> flash_sel_no);

  a_r8_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(bank_o));
endmodule

bind dsp_mem_decoder dmd_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .ps_ni          (ps_ni),
  .ds_ni          (ds_ni),
  .rd_ni          (rd_ni),
  .wr_ni          (wr_ni),
  .ram_and_sel_no (ram_and_sel_no),
  .ram_or_sel_no  (ram_or_sel_no),
  .flash_sel_no   (flash_sel_no),
  .bank_o         (bank_o),
  .and_en_i       (cfg.and_en),
  .commit_i       (commit)
);

// File: tb/dsp_mem_decoder_test.sv
module dsp_mem_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [15:0] addr = '0;
  logic        ps_n = 1'b1, ds_n = 1'b1, xy = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic        and_sel_n, or_sel_n, fl_sel_n;
  logic [2:0]  bank;

  int errors = 0, checks = 0;
  bit chk_on = 1'b0, done = 1'b0;
  bit m_en = 1'b0;
  int m_bank = 0;

  always #10 clk = ~clk;

  dsp_mem_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .spi_sck_i(sck), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .addr_i(addr), .ps_ni(ps_n), .ds_ni(ds_n), .xy_i(xy),
    .rd_ni(rd_n), .wr_ni(wr_n),
    .ram_and_sel_no(and_sel_n), .ram_or_sel_no(or_sel_n),
    .flash_sel_no(fl_sel_n), .bank_o(bank)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (addr=%h ps=%b ds=%b rd=%b wr=%b)",
               req, act, exp, addr, ps_n, ds_n, rd_n, wr_n);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (chk_on) begin
      bit acc, e_or, e_and, e_fl;
      acc   = (!ps_n || !ds_n) && (!rd_n || !wr_n);
      e_or  = !(acc && (addr[13] || addr[14]));
      e_and = !(acc && m_en && addr[13] && addr[14]);
      e_fl  = !(acc && !ps_n && addr[15] && (addr[14] == addr[13]));
      check(or_sel_n == e_or,   "R2/R3 ram_or_sel", int'(or_sel_n), int'(e_or));
      check(and_sel_n == e_and, "R2/R4 ram_and_sel", int'(and_sel_n), int'(e_and));
      check(fl_sel_n == e_fl,   "R2/R5 flash_sel", int'(fl_sel_n), int'(e_fl));
      check(int'(bank) == m_bank, "R8 bank hold", int'(bank), m_bank);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // send n bits of d, MSB first; update model when a full frame lands
  task automatic spi_send(input logic [15:0] d, input int n);
    chk_on = 1'b0;
    cs_n = 1'b0; tick(4);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = d[i]; tick(4);
      sck = 1'b1;  tick(4);
      sck = 1'b0;
    end
    tick(4);
    cs_n = 1'b1; tick(10);
    if (n >= 8) begin
      m_en   = d[7];
      m_bank = int'(d[2:0]);
    end
    chk_on = 1'b1;
  endtask

  task automatic sweep();
    for (int v = 0; v < 256; v++) begin
      addr = {v[2:0], 13'h0A5A ^ 13'(v * 37)};
      {ps_n, ds_n, xy, rd_n, wr_n} = v[7:3];
      tick(1);
    end
    {ps_n, ds_n, rd_n, wr_n} = 4'hF;
    tick(1);
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(2);
    // R1 reset state
    check(bank == 3'd0, "R1 reset bank", int'(bank), 0);
    check(and_sel_n && or_sel_n && fl_sel_n, "R1 reset selects high",
          int'({and_sel_n, or_sel_n, fl_sel_n}), 7);
    chk_on = 1'b1;
    // R4 disabled: full AND-term sweep stays high
    sweep();
    // R6 enable + bank 5, with ignored bits 6:3 set
    spi_send(16'h00FD, 8);
    check(bank == 3'd5, "R6 bank from bits 2:0", int'(bank), 5);
    sweep();
    // R6 enable off, bank 2
    spi_send(16'h007A, 8);
    check(bank == 3'd2, "R6 bank load", int'(bank), 2);
    // R7 short frame discarded
    spi_send(16'h0087, 5);
    check(bank == 3'd2, "R7 short frame discarded", int'(bank), 2);
    // R7 long frame keeps last 8 bits
    spi_send(16'h0383, 11);
    check(bank == 3'd3, "R7 long frame last bits", int'(bank), 3);
    addr = 16'h6000; ps_n = 1'b1; ds_n = 1'b0; rd_n = 1'b0; tick(1);
    check(and_sel_n == 1'b0, "R7 long frame enable bit", int'(and_sel_n), 0);
    {ps_n, ds_n, rd_n} = 3'b111; tick(1);
    // R8 sck toggles with cs high
    for (int i = 0; i < 6; i++) begin
      mosi = i[0]; sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    end
    check(bank == 3'd3, "R8 sck while deselected", int'(bank), 3);
    // R5 data-space access at flash address with both strobes
    addr = 16'hE000; ps_n = 1'b1; ds_n = 1'b0; wr_n = 1'b0; tick(1);
    check(fl_sel_n == 1'b1, "R5 no flash in data space", int'(fl_sel_n), 1);
    ps_n = 1'b0; tick(1);
    check(fl_sel_n == 1'b0, "R5 program priority", int'(fl_sel_n), 0);
    {ps_n, ds_n, wr_n} = 3'b111;
    sweep();
    done = 1'b1;
    chk_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule